// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Clock Generator

This block turns one fast oscillator clock into a pair of non-overlapping phase clocks, with their inverses, for a circulating shift register of storage cells. A chain of toggle stages divides the oscillator down to a slow base clock and a clock of twice that rate. Simple gating of those two decides, in each quarter of the base period, which phase (if any) is high. A phase-one pulse moves data between cells; a phase-two pulse holds it.

An enable input stands for the switch that powers the block from the supply trigger. While it is low the divider is held at zero and both phases stay low. When it rises, the first pulse produced is always a hold pulse, so the register never shifts on undefined start-up contents. All outputs come from flip-flops, so they are free of gating glitches.

Top module: `nonoverlap_clkgen`

## Requirements
- R1: The two phase outputs phaseOne and phaseTwo are never high in the same cycle.
- R2: With DIV_STAGES divider stages, the base period is 2^DIV_STAGES oscillator cycles and is split into four quarters of 2^(DIV_STAGES-2) cycles; counting from the cycle after enable is sampled high, phaseTwo is high during the second quarter, phaseOne during the fourth, and both are low in the first and third.
- R3: After enable rises, the first phase pulse to appear is on phaseTwo (hold), never phaseOne.
- R4: phaseOneN is always the inverse of phaseOne and phaseTwoN always the inverse of phaseTwo.
- R5: On the first rising clock edge at which enable is sampled low, both phases go low and both inverse outputs go high, and the divider restarts from its first quarter when enable returns.
- R6: While rst_n is low, phaseOne and phaseTwo are low and phaseOneN and phaseTwoN are high.
- R7: Between the end of any phase pulse and the start of the next, both phases are low for at least one full quarter.
- R8: While enable stays low, no phase pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Power switch from the supply trigger; high runs the generator |
| phaseOne | output | 1 | Transfer phase |
| phaseOneN | output | 1 | Inverse of phaseOne |
| phaseTwo | output | 1 | Hold phase |
| phaseTwoN | output | 1 | Inverse of phaseTwo |

## Verification
The bench builds the block with the default of three divider stages, which makes a base period of only eight oscillator cycles and a quarter of two. At that size the bench can walk through many full periods, and it can drop enable inside each of the four quarters, including partway through a pulse. It can then watch each restart begin with a hold pulse after a full low quarter.

// File: rtl/nonoverlap_clkgen_pkg.sv
package nonoverlap_clkgen_pkg;
  // Strobes passed from the divider control to the phase datapath.
  typedef struct packed {
    logic baseClk;  // divided base clock
    logic dblClk;   // clock at twice the base rate
    logic clear;    // force all phases inactive
  } divStrobes_t;
endpackage

// File: rtl/nonoverlap_divider.sv
module nonoverlap_divider
  import nonoverlap_clkgen_pkg::*;
#(
  parameter int DIV_STAGES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  output divStrobes_t strobes
);
  logic [DIV_STAGES-1:0] stageQ;
  logic [DIV_STAGES:0]   carry;

  assign carry[0] = 1'b1;

  // Each stage toggles when every lower stage is high: a synchronous
  // model of a ripple chain of divide-by-two flip-flops.
  for (genvar s = 0; s < DIV_STAGES; s++) begin : g_stage
    assign carry[s+1] = carry[s] & stageQ[s];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stageQ[s] <= 1'b0;
      end else if (!enable) begin
        stageQ[s] <= 1'b0;
      end else if (carry[s]) begin
        stageQ[s] <= ~stageQ[s];
      end
    end
  end

  always_comb begin
    strobes.baseClk = stageQ[DIV_STAGES-1];
    strobes.dblClk  = stageQ[DIV_STAGES-2];
    strobes.clear   = ~enable;
  end
endmodule

// File: rtl/nonoverlap_phases.sv
module nonoverlap_phases
  import nonoverlap_clkgen_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  divStrobes_t strobes,
  output logic        phaseOne,
  output logic        phaseOneN,
  output logic        phaseTwo,
  output logic        phaseTwoN
);
  logic oneNext;
  logic twoNext;

  // Quarter 1 (base low, double high) is hold; quarter 3 (both high) is
  // transfer; quarters 0 and 2 are the gaps.
  always_comb begin
    oneNext = strobes.baseClk & strobes.dblClk & ~strobes.clear;
    twoNext = ~strobes.baseClk & strobes.dblClk & ~strobes.clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseOne  <= 1'b0;
      phaseTwo  <= 1'b0;
      phaseOneN <= 1'b1;
      phaseTwoN <= 1'b1;
    end else begin
      phaseOne  <= oneNext;
      phaseTwo  <= twoNext;
      phaseOneN <= ~oneNext;
      phaseTwoN <= ~twoNext;
    end
  end
endmodule

// File: rtl/nonoverlap_clkgen.sv
module nonoverlap_clkgen
  import nonoverlap_clkgen_pkg::*;
#(
  parameter int DIV_STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic phaseOne,
  output logic phaseOneN,
  output logic phaseTwo,
  output logic phaseTwoN
);
  divStrobes_t divStrobes;

  nonoverlap_divider #(.DIV_STAGES(DIV_STAGES)) divider_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .strobes (divStrobes)
  );

  nonoverlap_phases phases_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (divStrobes),
    .phaseOne  (phaseOne),
    .phaseOneN (phaseOneN),
    .phaseTwo  (phaseTwo),
    .phaseTwoN (phaseTwoN)
  );
endmodule

// File: rtl/nonoverlap_clkgen_checker.sv
module nonoverlap_clkgen_checker #(
  parameter int DIV_STAGES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic phaseOne,
  input logic phaseOneN,
  input logic phaseTwo,
  input logic phaseTwoN
);
  localparam int QW = 1 << (DIV_STAGES - 2);
  localparam int CW = $clog2(QW + 2) + 1;

  logic [CW-1:0] runOne;
  logic [CW-1:0] runTwo;
  logic [CW-1:0] runLow;
  logic          sawHold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runOne  <= '0;
      runTwo  <= '0;
      runLow  <= '0;
      sawHold <= 1'b0;
    end else begin
      runOne <= phaseOne ? runOne + 1'b1 : '0;
      runTwo <= phaseTwo ? runTwo + 1'b1 : '0;
      if (phaseOne || phaseTwo) runLow <= '0;
      else if (runLow < CW'(QW + 1)) runLow <= runLow + 1'b1;
      if (!enable) sawHold <= 1'b0;
      else if (phaseTwo) sawHold <= 1'b1;
    end
  end

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(phaseOne && phaseTwo));

  assert_width_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(phaseOne) && $past(enable)) |-> (runOne == CW'(QW)));

  assert_width_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(phaseTwo) && $past(enable)) |-> (runTwo == CW'(QW)));

  assert_hold_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phaseOne) |-> sawHold);

  assert_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phaseOneN == !phaseOne) && (phaseTwoN == !phaseTwo));

  assert_disable_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!phaseOne && !phaseTwo && phaseOneN && phaseTwoN));

  assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phaseOne) || $rose(phaseTwo)) |-> (runLow >= CW'(QW)));
endmodule

bind nonoverlap_clkgen nonoverlap_clkgen_checker #(.DIV_STAGES(DIV_STAGES)) checker_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .phaseOne  (phaseOne),
  .phaseOneN (phaseOneN),
  .phaseTwo  (phaseTwo),
  .phaseTwoN (phaseTwoN)
);

// File: tb/nonoverlap_clkgen_tb_top.sv
module nonoverlap_clkgen_tb_top;
  localparam int STAGES = 3;
  localparam int PERIOD = 1 << STAGES;
  localparam int QSHIFT = STAGES - 2;

  typedef struct {
    logic  one;
    logic  two;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic phaseOne, phaseOneN, phaseTwo, phaseTwoN;

  int checks = 0;
  int errors = 0;
  int modelIdx = 0;
  bit seenPulse = 1'b0;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  nonoverlap_clkgen #(.DIV_STAGES(STAGES)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .phaseOne  (phaseOne),
    .phaseOneN (phaseOneN),
    .phaseTwo  (phaseTwo),
    .phaseTwoN (phaseTwoN)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: applies enable for n cycles and pushes the expected outputs
  // seen after each rising edge.
  task automatic runCycles(input bit en, input int n);
    for (int k = 0; k < n; k++) begin
      expItem_t item;
      int q;
      @(negedge clk);
      enable = en;
      @(posedge clk);
      #1;
      if (!en) begin
        item.one = 1'b0; item.two = 1'b0;
        item.tag = seenPulse ? "R5" : "R8";
        modelIdx = 0;
        seenPulse = 1'b0;
      end else begin
        q = (modelIdx >> QSHIFT) & 3;
        item.two = (q == 1);
        item.one = (q == 3);
        if (!seenPulse) item.tag = "R3";
        else if (!item.one && !item.two) item.tag = "R7";
        else item.tag = "R2";
        if (item.one || item.two) seenPulse = 1'b1;
        modelIdx = (modelIdx + 1) % PERIOD;
      end
      expQ.push_back(item);
    end
  endtask

  // Monitor: compares at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check(phaseOne == e.one, e.tag, "phaseOne", phaseOne, e.one);
        check(phaseTwo == e.two, e.tag, "phaseTwo", phaseTwo, e.two);
        check(phaseOneN == !e.one, "R4", "phaseOneN", phaseOneN, !e.one);
        check(phaseTwoN == !e.two, "R4", "phaseTwoN", phaseTwoN, !e.two);
        check(!(phaseOne && phaseTwo), "R1", "overlap", phaseOne & phaseTwo, 0);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        // R6: reset state
        check(phaseOne == 1'b0 && phaseTwo == 1'b0, "R6", "phases in reset",
              {phaseOne, phaseTwo}, 0);
        check(phaseOneN == 1'b1 && phaseTwoN == 1'b1, "R6", "inverses in reset",
              {phaseOneN, phaseTwoN}, 3);
        @(negedge clk);
        rst_n = 1'b1;
        runCycles(1'b0, 6);            // R8: idle while disabled
        runCycles(1'b1, 5 * PERIOD);   // R2 R3 R7: steady periods
        for (int cut = 0; cut < PERIOD; cut++) begin
          runCycles(1'b0, 1 + (cut % 3)); // R5: drop in each position
          runCycles(1'b1, PERIOD + cut);
        end
        runCycles(1'b0, 4);
        runCycles(1'b1, 3 * PERIOD);
        repeat (3) @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule